// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block sits beside the instruction fetch path of a 16-bit register-file microcontroller. Instruction bytes arrive one per beat on a valid/ready stream. A one-bit flag from the opcode decoder, sampled with the opcode byte, says whether the opcode uses the indexed addressing mode. For indexed opcodes the block collects the byte that picks the index register and the form. It then takes one or two offset bytes and the byte naming the destination or source register. It reads the index register through a one-cycle-latency register-file read port and adds the offset with the extension rule of the chosen form. The result is a 16-bit effective address, a data bank tag and the instruction length.

A two-byte bank prefix (0x10 followed by a bank number byte) may come before an instruction. It replaces the default data bank for that one instruction. Addresses in the low register window carry no bank tag. The opcode itself is not executed and no memory is accessed.

Top module: `idx_addr_gen`

## Requirements
- R1: The byte after an indexed opcode selects the form through its bit 0: 0 means short form (one offset byte) and 1 means long form (two offset bytes, low byte first). `outLong` reports the form with the result.
- R2: The index register address driven on `rfAddr` is that selector byte with bit 0 forced to 0, so 0x53 reads register 0x52 and 0x01 reads register 0x00.
- R3: In the short form the single offset byte is sign-extended to 16 bits before the addition.
- R4: In the long form the 16-bit offset is zero-extended and never treated as negative, so 0xF298 through register 0 gives 0xF298.
- R5: Register 0 contributes zero whatever `rfData` returns, which makes long indexing through it absolute 16-bit addressing.
- R6: `outLen` is 4 for the short form and 5 for the long form, and `outDestReg` is the last byte of the instruction.
- R7: A result address from 0x000 to 0x3FF has `outBankValid`=0 and `outBank`=0. Any higher address has `outBankValid`=1 and `outBank` set to the bank in force.
- R8: The default bank is taken from `defaultBank` on the cycle the opcode byte is accepted. Later changes do not affect that instruction.
- R9: A prefix byte 0x10 seen where an opcode is expected, followed by a bank byte whose low 4 bits give the bank, overrides the bank for the next instruction only. Any following opcode clears the override, indexed or not.
- R10: The index value plus the offset wraps modulo 2^16, with no carry into the bank.
- R11: `outValid` is high for exactly one cycle, the cycle after the final instruction byte is accepted. It stays low for every other byte.
- R12: A non-indexed opcode byte produces no result. A synchronous reset drops any partly received instruction and returns to waiting for an opcode. `inReady` is 1 whenever reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inByte | input | 8 | Instruction byte |
| inValid | input | 1 | Instruction byte valid |
| inReady | output | 1 | Block accepts a byte |
| isIndexed | input | 1 | Opcode uses indexed mode, qualified with the opcode byte |
| defaultBank | input | 4 | Default data bank |
| rfAddr | output | 8 | Register-file read address |
| rfData | input | 16 | Register-file read data, one cycle after rfAddr |
| outValid | output | 1 | Result pulse |
| outAddr | output | 16 | Effective address |
| outBank | output | 4 | Bank tag |
| outBankValid | output | 1 | Bank tag applies |
| outDestReg | output | 8 | Destination or source register |
| outLen | output | 3 | Instruction length in bytes |
| outLong | output | 1 | Long form used |

## Verification
The assertions assume `isIndexed` is meaningful only on the beat that carries an opcode. They also assume the register file returns data for `rfAddr` one cycle later. The bench models the register file with exactly that latency, and it gives register 0 a nonzero value so that R5 is really tested. Every byte the bench drives comes as a single valid beat at a falling edge, and an instruction never has more bytes than its form calls for. Between opcodes the bench changes `defaultBank` only where the R8 test sets out to do so.

// File: rtl/idx_addr_pkg.sv
package idx_addr_pkg;
  localparam int ByteW = 8;
  localparam int WordW = 16;
  localparam int BankW = 4;
  localparam int LenW = 3;
  localparam logic [ByteW-1:0] PrefixCode = 8'h10;
  localparam logic [WordW-1:0] RegWindowTop = 16'h03FF;

  typedef enum logic [2:0] {
    StOpc, StBankNum, StRegSel, StOffLo, StOffHi, StDest
  } parseState_t;

  typedef struct packed {
    logic latchOpc;
    logic setOvr;
    logic dropOvr;
    logic takeReg;
    logic takeLo;
    logic takeHi;
    logic takeDest;
  } ctrlStrobe_t;
endpackage

// File: rtl/idx_addr_ctrl.sv
module idx_addr_ctrl
  import idx_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ByteW-1:0] inByte,
  input  logic             inValid,
  input  logic             isIndexed,
  output logic             inReady,
  output ctrlStrobe_t      strobe
);
  parseState_t state, stateNext;
  logic longQ;
  logic accept;

  assign inReady = !rst;
  assign accept = inValid && inReady;

  always_comb begin
    stateNext = state;
    strobe = '0;
    if (accept) begin
      unique case (state)
        StOpc: begin
          if (inByte == PrefixCode) begin
            stateNext = StBankNum;
          end else if (isIndexed) begin
            strobe.latchOpc = 1'b1;
            stateNext = StRegSel;
          end else begin
            strobe.dropOvr = 1'b1;
          end
        end
        StBankNum: begin
          strobe.setOvr = 1'b1;
          stateNext = StOpc;
        end
        StRegSel: begin
          strobe.takeReg = 1'b1;
          stateNext = StOffLo;
        end
        StOffLo: begin
          strobe.takeLo = 1'b1;
          stateNext = longQ ? StOffHi : StDest;
        end
        StOffHi: begin
          strobe.takeHi = 1'b1;
          stateNext = StDest;
        end
        StDest: begin
          strobe.takeDest = 1'b1;
          strobe.dropOvr = 1'b1;
          stateNext = StOpc;
        end
        default: stateNext = StOpc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= StOpc;
      longQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.takeReg) longQ <= inByte[0];
    end
  end
endmodule

// File: rtl/idx_addr_dp.sv
module idx_addr_dp
  import idx_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ByteW-1:0] inByte,
  input  logic [BankW-1:0] defaultBank,
  input  ctrlStrobe_t      strobe,
  output logic [ByteW-1:0] rfAddr,
  input  logic [WordW-1:0] rfData,
  output logic             outValid,
  output logic [WordW-1:0] outAddr,
  output logic [BankW-1:0] outBank,
  output logic             outBankValid,
  output logic [ByteW-1:0] outDestReg,
  output logic [LenW-1:0]  outLen,
  output logic             outLong
);
  localparam int ExtW = WordW - ByteW;

  logic [ByteW-1:0] idxRegQ;
  logic             longQ;
  logic [ByteW-1:0] offLoQ, offHiQ;
  logic [BankW-1:0] defBankQ, ovrBankQ;
  logic             ovrQ;
  logic [WordW-1:0] offExt, idxVal, sum;
  logic [BankW-1:0] bankUse;

  assign rfAddr = idxRegQ;

  always_comb begin
    if (longQ) offExt = {offHiQ, offLoQ};
    else       offExt = {{ExtW{offLoQ[ByteW-1]}}, offLoQ};
    idxVal  = (idxRegQ == '0) ? '0 : rfData;
    sum     = idxVal + offExt;
    bankUse = ovrQ ? ovrBankQ : defBankQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idxRegQ  <= '0;
      longQ    <= 1'b0;
      offLoQ   <= '0;
      offHiQ   <= '0;
      defBankQ <= '0;
      ovrBankQ <= '0;
      ovrQ     <= 1'b0;
    end else begin
      if (strobe.latchOpc) defBankQ <= defaultBank;
      if (strobe.setOvr) begin
        ovrQ     <= 1'b1;
        ovrBankQ <= inByte[BankW-1:0];
      end else if (strobe.dropOvr) begin
        ovrQ <= 1'b0;
      end
      if (strobe.takeReg) begin
        idxRegQ <= {inByte[ByteW-1:1], 1'b0};
        longQ   <= inByte[0];
      end
      if (strobe.takeLo) offLoQ <= inByte;
      if (strobe.takeHi) offHiQ <= inByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid     <= 1'b0;
      outAddr      <= '0;
      outBank      <= '0;
      outBankValid <= 1'b0;
      outDestReg   <= '0;
      outLen       <= '0;
      outLong      <= 1'b0;
    end else begin
      outValid <= strobe.takeDest;
      if (strobe.takeDest) begin
        outAddr      <= sum;
        outBankValid <= (sum > RegWindowTop);
        outBank      <= (sum > RegWindowTop) ? bankUse : '0;
        outDestReg   <= inByte;
        outLen       <= longQ ? LenW'(5) : LenW'(4);
        outLong      <= longQ;
      end
    end
  end
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  inByte,
  input  logic        inValid,
  output logic        inReady,
  input  logic        isIndexed,
  input  logic [3:0]  defaultBank,
  output logic [7:0]  rfAddr,
  input  logic [15:0] rfData,
  output logic        outValid,
  output logic [15:0] outAddr,
  output logic [3:0]  outBank,
  output logic        outBankValid,
  output logic [7:0]  outDestReg,
  output logic [2:0]  outLen,
  output logic        outLong
);
  ctrlStrobe_t strobe;

  idx_addr_ctrl uCtrl (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid),
    .isIndexed(isIndexed), .inReady(inReady), .strobe(strobe)
  );

  idx_addr_dp uDp (
    .clk(clk), .rst(rst), .inByte(inByte), .defaultBank(defaultBank),
    .strobe(strobe), .rfAddr(rfAddr), .rfData(rfData),
    .outValid(outValid), .outAddr(outAddr), .outBank(outBank),
    .outBankValid(outBankValid), .outDestReg(outDestReg),
    .outLen(outLen), .outLong(outLong)
  );
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic [15:0] outAddr,
  input logic [3:0]  outBank,
  input logic        outBankValid,
  input logic [2:0]  outLen,
  input logic        outLong
);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  a_r11_after_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(inValid && inReady));

  a_r6_length_form: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((outLong && outLen == 3'd5) || (!outLong && outLen == 3'd4)));

  a_r7_window_untagged: assert property (@(posedge clk) disable iff (rst)
    (outValid && outAddr <= 16'h03FF) |-> (!outBankValid && outBank == 4'd0));

  a_r7_above_tagged: assert property (@(posedge clk) disable iff (rst)
    (outValid && outAddr > 16'h03FF) |-> outBankValid);

  a_r12_ready: assert property (@(posedge clk) disable iff (rst)
    inReady);
endmodule

bind idx_addr_gen idx_addr_gen_chk uChk (.*);

// File: tb/tb_idx_addr_gen.sv
module tb_idx_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        isIndexed = 1'b0;
  logic [3:0]  defaultBank = '0;
  logic [7:0]  rfAddr;
  logic [15:0] rfData;
  logic        outValid;
  logic [15:0] outAddr;
  logic [3:0]  outBank;
  logic        outBankValid;
  logic [7:0]  outDestReg;
  logic [2:0]  outLen;
  logic        outLong;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit earlyPulse;

  always #5 clk = ~clk;

  idx_addr_gen dut (.*);

  // register file model: one cycle latency, register 0 returns junk
  function automatic logic [15:0] regVal(input logic [7:0] a);
    return (a == 8'h00) ? 16'hDEAD : {a, 8'h40};
  endfunction
  always_ff @(posedge clk) rfData <= regVal(rfAddr);

  typedef struct packed {
    logic [7:0] regB;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] dest;
    logic       pref;
    logic [3:0] pb;
    logic [3:0] db;
  } vec_t;

  localparam int NVec = 9;
  localparam vec_t VECS [NVec] = '{
    '{8'h01, 8'h98, 8'hF2, 8'h44, 1'b0, 4'h0, 4'h1},
    '{8'h52, 8'h80, 8'h00, 8'h34, 1'b0, 4'h0, 4'h3},
    '{8'h00, 8'h7F, 8'h00, 8'h46, 1'b0, 4'h0, 4'h5},
    '{8'h01, 8'hFF, 8'h03, 8'h14, 1'b0, 4'h0, 4'h6},
    '{8'h01, 8'h00, 8'h04, 8'h16, 1'b0, 4'h0, 4'h6},
    '{8'h53, 8'h28, 8'h5D, 8'h4C, 1'b1, 4'h9, 4'h2},
    '{8'h53, 8'h28, 8'h5D, 8'h4C, 1'b0, 4'h0, 4'h2},
    '{8'hF1, 8'h00, 8'h20, 8'h50, 1'b0, 4'h0, 4'h7},
    '{8'h02, 8'hFF, 8'h00, 8'h52, 1'b0, 4'h0, 4'hA}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic idx);
    @(negedge clk);
    inByte = b; isIndexed = idx; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0; isIndexed = 1'b0;
  endtask

  // sends a full instruction; returns with the result visible at this negedge
  task automatic runInstr(input vec_t v, input bit changeDb, input logic [3:0] altDb);
    bit lng;
    lng = v.regB[0];
    earlyPulse = 1'b0;
    if (v.pref) begin
      sendByte(8'h10, 1'b0);
      if (outValid) earlyPulse = 1'b1;
      sendByte({4'h0, v.pb}, 1'b0);
      if (outValid) earlyPulse = 1'b1;
    end
    defaultBank = v.db;
    sendByte(8'hA3, 1'b1);
    if (outValid) earlyPulse = 1'b1;
    if (changeDb) defaultBank = altDb;
    sendByte(v.regB, 1'b0);
    if (outValid) earlyPulse = 1'b1;
    sendByte(v.lo, 1'b0);
    if (outValid) earlyPulse = 1'b1;
    if (lng) begin
      sendByte(v.hi, 1'b0);
      if (outValid) earlyPulse = 1'b1;
    end
    @(negedge clk);
    inByte = v.dest; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkResult(input vec_t v, input string tag);
    logic [15:0] idx, off, addr;
    logic [3:0] bank;
    bit lng, tagOn;
    lng = v.regB[0];
    idx = ({v.regB[7:1], 1'b0} == 8'h00) ? 16'h0000 : regVal({v.regB[7:1], 1'b0});
    off = lng ? {v.hi, v.lo} : {{8{v.lo[7]}}, v.lo};
    addr = idx + off;
    tagOn = addr > 16'h03FF;
    bank = tagOn ? (v.pref ? v.pb : v.db) : 4'h0;
    check(outValid == 1'b1 && !earlyPulse, "R11", {tag, " pulse"}, outValid, 1);
    check(outAddr == addr, "R3/R4/R5/R10", {tag, " addr"}, outAddr, addr);
    check(outBankValid == tagOn && outBank == bank, "R7/R9",
          {tag, " bank"}, {outBankValid, outBank}, {tagOn, bank});
    check(outLen == (lng ? 3'd5 : 3'd4) && outDestReg == v.dest, "R6",
          {tag, " len/dest"}, {outLen, outDestReg}, {(lng ? 3'd5 : 3'd4), v.dest});
    check(outLong == lng, "R1", {tag, " form"}, outLong, lng);
    @(negedge clk);
    check(outValid == 1'b0, "R11", {tag, " pulse end"}, outValid, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(outValid == 1'b0 && inReady == 1'b1, "R12", "reset state",
          {outValid, inReady}, 2'b01);

    for (int i = 0; i < NVec; i++) begin
      runInstr(VECS[i], 1'b0, 4'h0);
      checkResult(VECS[i], $sformatf("vec%0d", i));
    end

    // R2: register selector address with bit 0 cleared
    sendByte(8'hA3, 1'b1);
    sendByte(8'h53, 1'b0);
    check(rfAddr == 8'h52, "R2", "rfAddr from 0x53", rfAddr, 8'h52);
    sendByte(8'h10, 1'b0);
    sendByte(8'h20, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;

    // R8: default bank captured at opcode accept
    v = '{8'h01, 8'h00, 8'h80, 8'h60, 1'b0, 4'h0, 4'h4};
    runInstr(v, 1'b1, 4'hB);
    checkResult(v, "R8 late bank change");

    // R9 + R12: prefix cleared by a non-indexed opcode, which yields no result
    sendByte(8'h10, 1'b0);
    sendByte(8'h07, 1'b0);
    sendByte(8'h20, 1'b0);
    check(outValid == 1'b0, "R12", "non-indexed opcode no result", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R12", "non-indexed opcode no result later", outValid, 0);
    v = '{8'h01, 8'h00, 8'h90, 8'h62, 1'b0, 4'h0, 4'h4};
    runInstr(v, 1'b0, 4'h0);
    checkResult(v, "R9 override dropped");

    // R12: reset in mid-instruction then full instruction parses cleanly
    sendByte(8'h10, 1'b0);
    sendByte(8'h0C, 1'b0);
    sendByte(8'hA3, 1'b1);
    sendByte(8'h01, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    v = '{8'h00, 8'h10, 8'h00, 8'h66, 1'b0, 4'h0, 4'h8};
    runInstr(v, 1'b0, 4'h0);
    checkResult(v, "R12 after mid reset");
    v = '{8'h01, 8'h34, 8'h92, 8'h68, 1'b0, 4'h0, 4'h8};
    runInstr(v, 1'b0, 4'h0);
    checkResult(v, "R12 override gone after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule